// File: doc/BRIEF.md
# Converter Clock Prescaler and Conversion Timer

This block turns the system clock into a converter clock and paces a single analog conversion through its three timing phases. The converter clock is a one-cycle enable strobe, not a separate clock. A modulus counter first divides the system clock by (prescale + 1). A toggle stage then halves that rate. The result is one strobe every 2×(prescale + 1) system cycles, so the ratio runs from 2 to 64. A prescale value of zero skips the modulus stage, and only the halving remains.

A start pulse launches a conversion that counts converter-clock strobes through three phases. The state machine has four states:
- **ST_IDLE**: waiting for start.
- **ST_INIT**: a fixed initial sample lasting 2 strobes.
- **ST_SAMP**: a programmable sample lasting 2, 4, 8 or 16 strobes.
- **ST_RES**: the resolution period, lasting 10 strobes at 10-bit resolution or 8 strobes at 8-bit resolution.

The transitions are:
- **T_GO**: ST_IDLE to ST_INIT on start without abort.
- **T_SAMPLE**: ST_INIT to ST_SAMP on the last initial strobe.
- **T_RESOLVE**: ST_SAMP to ST_RES on the last sample strobe.
- **T_DONE**: ST_RES to ST_IDLE on the last resolution strobe.
- **T_ABORT**: any busy state to ST_IDLE on abort.

The surrounding converter uses the sampling indicator to close its sample switch, the converting indicator to run its comparator, and the done pulse to capture the result.

Top module: `adc_conv_timer`

## Requirements
- R1: After reset the block is in ST_IDLE, and cclk_en, sampling, converting and done are all 0.
- R2: While a conversion runs, cclk_en is high for exactly one system cycle in every 2×(P+1) cycles, where P is the prescale value captured at start. The first strobe comes in the (2×(P+1))-th cycle after the clock edge that accepts start.
- R3: A prescale value of 0 gives a strobe every 2 system cycles, with the modulus stage bypassed.
- R4: Each conversion opens with an initial sample phase of exactly 2 strobes, during which sampling is 1 and converting is 0. The sampling and converting indicators are never high together.
- R5: The programmable sample phase that follows lasts 2, 4, 8 or 16 strobes for smp_sel = 0, 1, 2 or 3. Sampling stays 1 for the whole of it.
- R6: The resolution phase follows the sample phase, with converting = 1. It lasts 10 strobes when res8_sel = 0 and 8 strobes when res8_sel = 1.
- R7: done is high for exactly one system cycle, in the same cycle as the final resolution strobe. The next cycle is idle. At 10-bit resolution a conversion takes 14 strobes at the shortest sample setting and 28 at the longest.
- R8: Asserting abort returns the block to idle at the next clock edge, with sampling, converting and cclk_en all 0. done stays 0 in the abort cycle, even when that cycle holds the final strobe.
- R9: prs_val, smp_sel and res8_sel are captured when start is accepted. Changing them, or pulsing start again, during a conversion has no effect on its timing.
- R10: cclk_en is 0 whenever no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prs_val | input | 5 | Prescale value P (division ratio 2×(P+1)) |
| smp_sel | input | 2 | Sample-phase length select (2 << smp_sel strobes) |
| res8_sel | input | 1 | 1 = 8-bit resolution period, 0 = 10-bit |
| start | input | 1 | Start a conversion when idle |
| abort | input | 1 | Cancel the running conversion |
| cclk_en | output | 1 | Converter clock strobe, one system cycle wide |
| sampling | output | 1 | High during the initial and programmable sample phases |
| converting | output | 1 | High during the resolution phase |
| done | output | 1 | One-cycle pulse on the final resolution strobe |

## Verification
The bench times every strobe against the captured prescale value.

- **Divider off by one:** a divider with an off-by-one modulus, or one that skips the halving stage, shows up as wrong strobe spacing or a misplaced first strobe. This is checked at both extremes, P = 0 and P = 31.
- **Phase lengths:** counting strobes per indicator exposes a sample phase of the wrong length, or a swapped meaning of the resolution bit.
- **Done placement:** a done pulse that comes one cycle late, or lasts two cycles, is caught.
- **Abort on the final strobe:** an abort in the same cycle as the final strobe is checked, so a design that lets done escape the abort fails.
- **Mid-conversion changes:** settings are changed and start is pulsed again in the middle of a run, so a design that reads the live inputs fails.

// File: rtl/adc_tmr_pkg.sv
package adc_tmr_pkg;

    localparam int PRS_W   = 5;
    localparam int SMP_W   = 2;
    localparam int PHASE_W = 5;
    localparam int INIT_LEN = 2;
    localparam int RES_HI_LEN = 10;
    localparam int RES_LO_LEN = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_SAMP,
        ST_RES
    } tmr_state_e;

    function automatic logic [PHASE_W-1:0] samp_len(input logic [SMP_W-1:0] sel);
        return PHASE_W'(2) << sel;
    endfunction

    function automatic logic [PHASE_W-1:0] res_len(input logic hi_short);
        return hi_short ? PHASE_W'(RES_LO_LEN) : PHASE_W'(RES_HI_LEN);
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int PRS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRS_W-1:0] prs,
    output logic             tick_en
);

    logic [PRS_W-1:0] mod_cnt;
    logic             half_q;
    logic             mod_tick;

    // Modulus stage: wraps after prs+1 cycles; prs == 0 ticks every cycle (bypass)
    assign mod_tick = (mod_cnt == prs);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_cnt <= '0;
            half_q  <= 1'b0;
        end else if (!run) begin
            mod_cnt <= '0;
            half_q  <= 1'b0;
        end else if (mod_tick) begin
            mod_cnt <= '0;
            half_q  <= ~half_q;
        end else begin
            mod_cnt <= mod_cnt + 1'b1;
        end
    end

    // Divide-by-2 stage: every second modulus tick becomes a strobe
    assign tick_en = run && mod_tick && half_q;

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             cen,
    input  logic [PRS_W-1:0] prs_in,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             res8_in,
    output logic [PRS_W-1:0] prs_q,
    output logic             busy,
    output logic             sampling,
    output logic             converting,
    output logic             done
);

    tmr_state_e         state_q, state_d;
    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] cur_len;
    logic [SMP_W-1:0]   smp_q;
    logic               res8_q;
    logic               last_tick;
    logic               go;

    assign go = start && !abort;

    always_comb begin
        unique case (state_q)
            ST_INIT: cur_len = PHASE_W'(INIT_LEN);
            ST_SAMP: cur_len = samp_len(smp_q);
            ST_RES:  cur_len = res_len(res8_q);
            default: cur_len = PHASE_W'(INIT_LEN);
        endcase
    end

    assign last_tick = cen && (cnt_q == cur_len - 1'b1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_INIT;                    // T_GO
            ST_INIT: if (abort) state_d = ST_IDLE;                 // T_ABORT
                     else if (last_tick) state_d = ST_SAMP;        // T_SAMPLE
            ST_SAMP: if (abort) state_d = ST_IDLE;
                     else if (last_tick) state_d = ST_RES;         // T_RESOLVE
            ST_RES:  if (abort) state_d = ST_IDLE;
                     else if (last_tick) state_d = ST_IDLE;        // T_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, phase counter and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            prs_q   <= '0;
            smp_q   <= '0;
            res8_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && go) begin
                prs_q  <= prs_in;
                smp_q  <= smp_in;
                res8_q <= res8_in;
            end
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (cen) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        busy       = 1'b0;
        sampling   = 1'b0;
        converting = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_INIT: begin busy = 1'b1; sampling = 1'b1; end
            ST_SAMP: begin busy = 1'b1; sampling = 1'b1; end
            ST_RES: begin
                busy       = 1'b1;
                converting = 1'b1;
                done       = last_tick && !abort;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRS_W-1:0] prs_val,
    input  logic [SMP_W-1:0] smp_sel,
    input  logic             res8_sel,
    input  logic             start,
    input  logic             abort,
    output logic             cclk_en,
    output logic             sampling,
    output logic             converting,
    output logic             done
);

    logic [PRS_W-1:0] prs_q;
    logic             busy;
    logic             tick;

    adc_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .abort      (abort),
        .cen        (tick),
        .prs_in     (prs_val),
        .smp_in     (smp_sel),
        .res8_in    (res8_sel),
        .prs_q      (prs_q),
        .busy       (busy),
        .sampling   (sampling),
        .converting (converting),
        .done       (done)
    );

    adc_clk_div #(.PRS_W(PRS_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .prs     (prs_q),
        .tick_en (tick)
    );

    assign cclk_en = tick;

endmodule

// File: rtl/adc_conv_timer_chk.sv
module adc_conv_timer_chk
    import adc_tmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PRS_W-1:0] prs_val,
    input logic [SMP_W-1:0] smp_sel,
    input logic             res8_sel,
    input logic             start,
    input logic             abort,
    input logic             cclk_en,
    input logic             sampling,
    input logic             converting,
    input logic             done
);

    assert_done_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cclk_en && converting));

    assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!converting && !sampling && !done));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!sampling && !converting && !cclk_en));

    assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sampling && converting));

    assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en |-> (sampling || converting));

    assert_res_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converting) |-> $past(sampling));

    assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && !sampling && !converting) |=> sampling);

endmodule

bind adc_conv_timer adc_conv_timer_chk u_chk (.*);

// File: tb/adc_conv_timer_bench.sv
module adc_conv_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] prs_val = '0;
    logic [1:0] smp_sel = '0;
    logic       res8_sel = 1'b0;
    logic       start = 1'b0;
    logic       abort = 1'b0;
    logic       cclk_en, sampling, converting, done;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_conv_timer u_adc_conv_timer (
        .clk(clk), .rst_n(rst_n), .prs_val(prs_val), .smp_sel(smp_sel),
        .res8_sel(res8_sel), .start(start), .abort(abort),
        .cclk_en(cclk_en), .sampling(sampling), .converting(converting), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one conversion; meddle changes settings and re-pulses start mid-run (R9)
    task automatic run_conv(input int p, input int s, input int r, input bit meddle);
        int per, n_samp_exp, n_res_exp, n_tot;
        int first_k, last_k, n_samp, n_res, done_k, bad_gap;
        per        = 2 * (p + 1);
        n_samp_exp = 2 + (2 << s);
        n_res_exp  = r ? 8 : 10;
        n_tot      = n_samp_exp + n_res_exp;
        first_k = -1; last_k = -1; n_samp = 0; n_res = 0; done_k = -1; bad_gap = 0;
        @(negedge clk);
        prs_val = 5'(p); smp_sel = 2'(s); res8_sel = 1'(r); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (meddle) begin
            prs_val = 5'(p ^ 5'h1f); smp_sel = 2'(s ^ 3); res8_sel = 1'(!r);
        end
        for (int k = 0; k < 3000; k++) begin
            if (cclk_en) begin
                if (first_k < 0) first_k = k;
                else if (k - last_k != per) bad_gap++;
                last_k = k;
                if (sampling) n_samp++;
                if (converting) n_res++;
            end
            if (done) begin
                done_k = k;
                check(cclk_en == 1'b1, "R7 done with strobe", int'(cclk_en), 1);
                break;
            end
            if (meddle && k == 5) start = 1'b1;
            if (meddle && k == 6) start = 1'b0;
            @(negedge clk);
        end
        check(first_k == per - 1, "R2 first strobe cycle", first_k, per - 1);
        check(bad_gap == 0, "R2/R3 strobe spacing", bad_gap, 0);
        check(n_samp == n_samp_exp, "R4/R5 sampling strobes", n_samp, n_samp_exp);
        check(n_res == n_res_exp, "R6 resolution strobes", n_res, n_res_exp);
        check(done_k == per * n_tot - 1, "R7 done cycle", done_k, per * n_tot - 1);
        if (meddle) check(done_k == per * n_tot - 1, "R9 settings held", done_k, per * n_tot - 1);
        @(negedge clk);
        check(!sampling && !converting && !done && !cclk_en, "R7 idle after done",
              int'({sampling, converting, done, cclk_en}), 0);
    endtask

    // Abort at cycle k_ab after start; stays idle with no done afterwards (R8)
    task automatic abort_at(input int k_ab);
        int done_seen;
        done_seen = 0;
        @(negedge clk);
        prs_val = 5'd2; smp_sel = 2'd0; res8_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < k_ab; k++) begin
            if (done) done_seen++;
            @(negedge clk);
        end
        abort = 1'b1;
        #1;
        check(done == 1'b0, "R8 done suppressed in abort cycle", int'(done), 0);
        @(negedge clk);
        abort = 1'b0;
        check(!sampling && !converting && !cclk_en, "R8 idle after abort",
              int'({sampling, converting, cclk_en}), 0);
        for (int k = 0; k < 120; k++) begin
            if (done || cclk_en || sampling) done_seen++;
            @(negedge clk);
        end
        check(done_seen == 0, "R8/R10 no activity after abort", done_seen, 0);
    endtask

    task automatic test_reset();
        int active;
        active = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (cclk_en || sampling || converting || done) active++;
        end
        check(active == 0, "R1/R10 idle after reset", active, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_conv(0, 0, 0, 1'b0);   // R3: bypass, 14 strobes
        run_conv(0, 3, 0, 1'b0);   // R7: 28 strobes
        run_conv(3, 1, 1, 1'b0);   // R5/R6: 8-bit
        run_conv(31, 2, 1, 1'b0);  // R2: maximum ratio
        run_conv(1, 2, 0, 1'b1);   // R9: settings changed mid-run
        abort_at(10);              // R8: mid sample
        abort_at(83);              // R8: on final strobe (6*14-1)
        run_conv(4, 0, 1, 1'b0);   // R1: recovers after abort
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule